// File: doc/BRIEF.md
# Serial DAC Load Interface

This block is the digital front end of a serially loaded voltage-output DAC. A host drives three wires: an active-low frame strobe (`fsync_n`), a serial clock (`sclk`) and a data line (`sdin`). All three are brought into the faster system clock domain through synchronizer stages, and edges are detected there. While the strobe is low, each falling `sclk` edge moves one data bit into the block, most significant bit first. A complete 16-bit word loads two things at once: a 2-bit output-stage mode and a DAC code of `RES_BITS` bits (12 or 14).

A frame only takes effect on its sixteenth falling clock edge. If the strobe is released before that edge, the partial word is thrown away and nothing changes. After power-on reset the code holds either zero or midscale, chosen by a parameter, and the mode is normal. These values stay until the first complete frame.

The mode bits drive the enables for the analog output stage. In normal mode the buffer amplifier drives the pin. The three power-down modes instead connect the pin to ground through a 1 kΩ load or a 100 kΩ load, or leave it open. The code register is never cleared by power-down. Each load produces a single-cycle `upd_stb` alongside the new code and mode. It is a plain strobe without back-pressure, because the analog side accepts every update.

Top module: `sdac_frontend`

## Requirements
- R1: During and after reset, `dac_code` equals midscale (MSB set, other bits zero) when `MIDSCALE_RST` is 1 and zero when it is 0. `pd_mode` is 00, and nothing changes until a complete frame arrives.
- R2: A falling `fsync_n` starts a frame. Each later falling `sclk` edge while `fsync_n` stays low takes one `sdin` bit, most significant bit first.
- R3: In the 16-bit word, bits 15:14 form the mode. The code is bits 13:(14-RES_BITS), so at 12-bit resolution bits 1:0 have no effect.
- R4: The sixteenth falling edge of a frame loads code and mode together and raises `upd_stb` for exactly one clock cycle. With `SYNC_STAGES`=2, the new outputs appear after the fourth rising `clk` edge, counting from the first edge that samples `sclk` low.
- R5: If `fsync_n` is high before the sixteenth falling edge is seen, the frame is discarded: code and mode keep their values and no strobe fires. If the release and the sixteenth fall are sampled in the same cycle, the release wins.
- R6: Falling `sclk` edges after the sixteenth in the same frame have no effect until `fsync_n` has gone high and low again.
- R7: The mode decodes as follows. 00 gives `amp_en`=1 and `out_connect`=1. 01 gives `sel_1k`=1. 10 gives `sel_100k`=1. 11 gives `out_connect`=0 with `amp_en`, `sel_1k` and `sel_100k` all 0. In modes 01 and 10, `out_connect` is 1 and `amp_en` is 0.
- R8: While a power-down mode is active, `dac_code` keeps the last loaded code.
- R9: `fsync_n` may stay low after a completed frame. A new frame begins only after `fsync_n` has been high for at least two `clk` cycles and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_n | input | 1 | Frame strobe, active low, asynchronous |
| sclk | input | 1 | Serial clock, data taken on falling edge, asynchronous |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | RES_BITS | Code held for the converter |
| pd_mode | output | 2 | Current output-stage mode |
| upd_stb | output | 1 | One-cycle pulse when code and mode load |
| amp_en | output | 1 | Output amplifier and analog core enabled |
| sel_1k | output | 1 | Pin tied to ground through 1 kΩ |
| sel_100k | output | 1 | Pin tied to ground through 100 kΩ |
| out_connect | output | 1 | Pin driven or loaded (low means open) |

## Verification
The bench checks the outputs on every clock against a behavioural model of the serial protocol. It drives frames that stop at 7 and 15 bits, and a frame that releases the strobe in the same cycle as the sixteenth fall. A design that counted one edge too few, or let the release lose that race, would load a code there. It also sends words that differ only in their don't-care low bits, extra clock edges after the sixteenth, and a strobe held low between frames. These catch a design that shifts the wrong field into the code, or that reloads from trailing edges. Power-down frames are followed by checks that the code stays put and that exactly one output-stage select is active.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_BITS = 16;
  localparam int MODE_BITS = 2;

  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_GND_1K = 2'b01,
    PD_GND_100K = 2'b10,
    PD_OPEN = 2'b11
  } pd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SHIFT = 2'b01,
    ST_DONE = 2'b10
  } frame_st_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d_async;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_s,
  input  logic                fs_s,
  input  logic                din_s,
  output logic                word_valid,
  output logic [MODE_BITS-1:0] word_mode,
  output logic [RES_BITS-1:0] word_code
);
  localparam int PAYLOAD = RES_BITS + MODE_BITS;
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] PAY_CNT = CNT_W'(PAYLOAD);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_BITS - 1);

  frame_st_e st;
  logic [CNT_W-1:0] cnt;
  logic [PAYLOAD-1:0] pay;
  logic sclk_p, fs_p;
  logic sclk_fall, fs_fall;

  assign sclk_fall = sclk_p & ~sclk_s;
  assign fs_fall = fs_p & ~fs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt <= '0;
      pay <= '0;
      word_valid <= 1'b0;
      sclk_p <= 1'b0;
      fs_p <= 1'b1;
    end else begin
      word_valid <= 1'b0;
      sclk_p <= sclk_s;
      fs_p <= fs_s;
      case (st)
        ST_IDLE: begin
          if (fs_fall) begin
            st <= ST_SHIFT;
            cnt <= '0;
            pay <= '0;
          end
        end
        ST_SHIFT: begin
          if (fs_s) begin
            st <= ST_IDLE;
            cnt <= '0;
            pay <= '0;
          end else if (sclk_fall) begin
            if (cnt < PAY_CNT) pay <= {pay[PAYLOAD-2:0], din_s};
            if (cnt == LAST_CNT) begin
              word_valid <= 1'b1;
              st <= ST_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (fs_s) begin
            st <= ST_IDLE;
            cnt <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign word_mode = pay[PAYLOAD-1 -: MODE_BITS];
  assign word_code = pay[RES_BITS-1:0];

  assert_done_after_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (st == ST_DONE));
  assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT && fs_s) |=> (st == ST_IDLE && !word_valid));
  assert_ignore_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && !fs_s) |=> !word_valid);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter bit MIDSCALE_RST = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [MODE_BITS-1:0] load_mode,
  input  logic [RES_BITS-1:0]  load_code,
  output logic [RES_BITS-1:0]  code_q,
  output pd_mode_e             mode_q,
  output logic                 upd_stb
);
  localparam logic [RES_BITS-1:0] RST_CODE =
    MIDSCALE_RST ? (RES_BITS'(1) << (RES_BITS - 1)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      mode_q <= PD_NORMAL;
      upd_stb <= 1'b0;
    end else begin
      upd_stb <= load;
      if (load) begin
        code_q <= load_code;
        mode_q <= pd_mode_e'(load_mode);
      end
    end
  end

  assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(code_q) && $stable(mode_q) && !upd_stb));
endmodule

// File: rtl/sdac_outsel.sv
module sdac_outsel
  import sdac_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pd_mode_e mode,
  output logic     amp_en,
  output logic     sel_1k,
  output logic     sel_100k,
  output logic     out_connect
);
  always_comb begin
    amp_en = 1'b0;
    sel_1k = 1'b0;
    sel_100k = 1'b0;
    out_connect = 1'b1;
    case (mode)
      PD_NORMAL: amp_en = 1'b1;
      PD_GND_1K: sel_1k = 1'b1;
      PD_GND_100K: sel_100k = 1'b1;
      default: out_connect = 1'b0;
    endcase
  end

  assert_one_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({amp_en, sel_1k, sel_100k}));
  assert_open_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_connect |-> !(amp_en | sel_1k | sel_100k));
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter bit MIDSCALE_RST = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fsync_n,
  input  logic                sclk,
  input  logic                sdin,
  output logic [RES_BITS-1:0] dac_code,
  output logic [1:0]          pd_mode,
  output logic                upd_stb,
  output logic                amp_en,
  output logic                sel_1k,
  output logic                sel_100k,
  output logic                out_connect
);
  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b100;

  logic [PIN_W-1:0] pins_s;
  logic word_valid;
  logic [MODE_BITS-1:0] word_mode;
  logic [RES_BITS-1:0] word_code;
  pd_mode_e mode_q;

  sdac_sync #(.STAGES(SYNC_STAGES), .W(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({fsync_n, sclk, sdin}),
    .q_sync(pins_s)
  );

  sdac_shift #(.RES_BITS(RES_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .fs_s(pins_s[2]), .din_s(pins_s[0]),
    .word_valid(word_valid), .word_mode(word_mode), .word_code(word_code)
  );

  sdac_regs #(.RES_BITS(RES_BITS), .MIDSCALE_RST(MIDSCALE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .load(word_valid), .load_mode(word_mode), .load_code(word_code),
    .code_q(dac_code), .mode_q(mode_q), .upd_stb(upd_stb)
  );

  sdac_outsel u_outsel (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .amp_en(amp_en), .sel_1k(sel_1k), .sel_100k(sel_100k),
    .out_connect(out_connect)
  );

  assign pd_mode = mode_q;

  assert_pd_keeps_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_stb && mode_q != PD_NORMAL) |-> $stable(dac_code));
endmodule

// File: tb/test_sdac_frontend.sv
module test_sdac_frontend;
  localparam int RES = 12;
  localparam int DC = 14 - RES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic [RES-1:0] dac_code;
  logic [1:0] pd_mode;
  logic upd_stb, amp_en, sel_1k, sel_100k, out_connect;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdac_frontend #(.RES_BITS(RES), .MIDSCALE_RST(1'b1), .SYNC_STAGES(2)) i_sdac_frontend (
    .clk(clk), .rst_n(rst_n), .fsync_n(fsync_n), .sclk(sclk), .sdin(sdin),
    .dac_code(dac_code), .pd_mode(pd_mode), .upd_stb(upd_stb), .amp_en(amp_en),
    .sel_1k(sel_1k), .sel_100k(sel_100k), .out_connect(out_connect)
  );

  // Behavioural model: pin history, frame bookkeeping with integers.
  logic [2:0] hist [5];
  int m_code, m_mode, m_cnt, m_word;
  bit m_in_frame, m_upd;

  initial for (int i = 0; i < 5; i++) hist[i] = 3'b100;

  always @(posedge clk) begin
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = {fsync_n, sclk, sdin};
    m_upd = 1'b0;
    if (!rst_n) begin
      m_code = 1 << (RES - 1);
      m_mode = 0;
      m_in_frame = 1'b0;
      m_cnt = 0;
      m_word = 0;
    end else begin
      if (hist[3][2]) begin
        m_in_frame = 1'b0;
      end else if (hist[4][2]) begin
        m_in_frame = 1'b1;
        m_cnt = 0;
        m_word = 0;
      end else if (m_in_frame && hist[4][1] && !hist[3][1]) begin
        m_word = (m_word << 1) | int'(hist[3][0]);
        m_cnt++;
        if (m_cnt == 16) begin
          m_in_frame = 1'b0;
          m_mode = (m_word >> 14) & 3;
          m_code = (m_word >> DC) & ((1 << RES) - 1);
          m_upd = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4", "dac_code", int'(dac_code), m_code);
      chk("R4", "pd_mode", int'(pd_mode), m_mode);
      chk("R4", "upd_stb", int'(upd_stb), int'(m_upd));
      chk("R7", "amp_en", int'(amp_en), int'(m_mode == 0));
      chk("R7", "sel_1k", int'(sel_1k), int'(m_mode == 1));
      chk("R7", "sel_100k", int'(sel_100k), int'(m_mode == 2));
      chk("R7", "out_connect", int'(out_connect), int'(m_mode != 3));
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits falling edges, then extra edges, optional release together with last fall
  task automatic send(input logic [15:0] w, input int nbits, input int extra,
                      input bit same_cycle, input bit keep_low);
    @(negedge clk);
    fsync_n = 1'b0;
    wt(4);
    for (int i = 0; i < nbits; i++) begin
      sdin = w[15-i];
      sclk = 1'b1;
      wt(4);
      sclk = 1'b0;
      if (same_cycle && i == nbits - 1) fsync_n = 1'b1;
      wt(4);
    end
    for (int i = 0; i < extra; i++) begin
      sdin = ~sdin;
      sclk = 1'b1;
      wt(4);
      sclk = 1'b0;
      wt(4);
    end
    if (keep_low) wt(12);
    fsync_n = 1'b1;
    wt(8);
  endtask

  task automatic expect_state(input string tag, input int code, input int mode);
    chk(tag, "dac_code", int'(dac_code), code);
    chk(tag, "pd_mode", int'(pd_mode), mode);
  endtask

  initial begin
    wt(6);
    chk("R1", "dac_code in reset", int'(dac_code), 'h800);
    rst_n = 1'b1;
    wt(4);
    expect_state("R1", 'h800, 0);
    chk("R1", "amp_en", int'(amp_en), 1);

    send(16'h1234, 16, 0, 1'b0, 1'b0);
    expect_state("R2", 'h48D, 0);

    send(16'h5ABC, 16, 0, 1'b0, 1'b0);
    expect_state("R8", 'h6AF, 1);
    chk("R7", "sel_1k", int'(sel_1k), 1);
    chk("R7", "amp_en", int'(amp_en), 0);

    send(16'h9ABD, 16, 0, 1'b0, 1'b0);
    expect_state("R3", 'h6AF, 2);
    chk("R7", "sel_100k", int'(sel_100k), 1);

    send(16'hFFFF, 16, 0, 1'b0, 1'b0);
    expect_state("R7", 'hFFF, 3);
    chk("R7", "out_connect", int'(out_connect), 0);

    send(16'h0000, 7, 0, 1'b0, 1'b0);
    expect_state("R5", 'hFFF, 3);
    send(16'h0000, 15, 0, 1'b0, 1'b0);
    expect_state("R5", 'hFFF, 3);
    send(16'h0000, 16, 0, 1'b1, 1'b0);
    expect_state("R5", 'hFFF, 3);

    send(16'h2468, 16, 5, 1'b0, 1'b0);
    expect_state("R6", 'h91A, 0);

    send(16'h4001, 16, 0, 1'b0, 1'b1);
    expect_state("R9", 'h000, 1);
    send(16'h0FF0, 16, 0, 1'b0, 1'b0);
    expect_state("R9", 'h3FC, 0);

    for (int k = 0; k < 25; k++) begin
      logic [15:0] w;
      int nb;
      w = 16'($urandom);
      nb = ($urandom % 4 == 0) ? int'($urandom % 16) : 16;
      send(w, nb, int'($urandom % 3), 1'b0, bit'($urandom % 2));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule